// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of one cache line in a write-back, invalidation-based snooping system. The line is in one of four states: invalid, exclusive-clean (the only copy, same as memory), shared (other copies may exist) or modified (the only copy, newer than memory). Two sources move the line between these states. The local processor issues reads, writes and evictions. The other caches' transactions arrive on the snoop port, and the controller watches them there.

When a processor operation needs the bus, the controller holds one request with its command until the arbiter grants it. The local state changes only in the grant cycle, so every write that needs the bus is ordered by the bus. When a read is granted, the controller samples the wired-OR shared line. If it is low the line fills as exclusive, and if it is high the line fills as shared. On snooped traffic the controller drives the shared line for reads it holds a copy for, and it asks for a data flush whenever it gives up a modified copy. A parameter sets the command used for a write to a shared line: a data-less upgrade or a full read-exclusive.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line is invalid (state code 0), no bus request is pending and the processor port is ready. State codes are invalid 0, shared 1, exclusive 2, modified 3.
- R2: A read in the invalid state requests bus command 1 (read). In the grant cycle the shared input is sampled, and the line becomes exclusive (2) if it is low or shared (1) if it is high.
- R3: A read in shared, exclusive or modified completes in the cycle it is accepted (done high), raises no bus request and leaves the state unchanged.
- R4: A write in exclusive completes at once and moves the line to modified with no bus request. A write in modified completes at once and keeps the state.
- R5: A write in invalid requests command 2 (read-exclusive). A write in shared requests command 3 (upgrade) when UPGRADE_EN is 1, or command 2 when it is 0. Either request moves the line to modified when it is granted.
- R6: A snooped read (command 1) to a valid line drives shared_o in that cycle. In modified it also raises flush_o and moves the line to shared. In exclusive it moves the line to shared. A snooped write-back (command 4) has no effect.
- R7: A snooped read-exclusive (2) or upgrade (3) moves any valid line to invalid. flush_o is raised only if the line was modified.
- R8: Evicting a shared or exclusive line drops it to invalid at once with no bus request. Evicting a modified line requests command 4 (write-back), raises flush_o in the grant cycle and leaves the line invalid.
- R9: A pending request keeps its command and the line keeps its state until the grant arrives.
- R10: A pending upgrade becomes a read-exclusive if a snoop invalidates the line before the grant.
- R11: A pending write-back is dropped, with done pulsed, if a snoop leaves the line not modified, for example a snooped read that flushes the data.
- R12: cpu_ready_o is low while a request is pending or a snoop is presented. A processor request given in such a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cpu_valid_i | input | 1 | Processor operation present |
| cpu_op_i | input | 2 | Operation: 0 read, 1 write, 2 evict, 3 no-op |
| cpu_ready_o | output | 1 | Operation can be accepted this cycle |
| cpu_done_o | output | 1 | Operation completes this cycle |
| bus_req_o | output | 1 | Bus request pending |
| bus_cmd_o | output | 3 | Requested command: 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_grant_i | input | 1 | Arbiter grants the pending request |
| snoop_valid_i | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd_i | input | 3 | Snooped command, same codes as bus_cmd_o |
| shared_i | input | 1 | Wired-OR shared line value |
| shared_o | output | 1 | This cache holds a copy of a snooped read |
| flush_o | output | 1 | Supply the line's data to the bus |
| state_o | output | 2 | Current coherence state |

## Verification
The assertions check the following on every cycle:
- flush is raised only from a modified line;
- the shared line is driven only for a valid line under a snoop;
- a pending request and the line state stay frozen until grant;
- the fill state follows the sampled shared value;
- snooped invalidations take effect;
- an upgrade turns into a read-exclusive after a snoop invalidates the line.

Other behaviour shows only in the bench's scenarios:
- the full sweep of every start state against every processor operation and every snoop command, run on both command variants;
- the race in which a snoop cancels an eviction's write-back;
- requests that arrive while the port is busy.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   localparam int ST_W  = 2;
   localparam int CMD_W = 3;
   localparam int OP_W  = 2;

   typedef enum logic [ST_W-1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2,
      LS_MOD = 2'd3
   } line_state_e;

   typedef enum logic [CMD_W-1:0] {
      BC_NONE  = 3'd0,
      BC_READ  = 3'd1,
      BC_READX = 3'd2,
      BC_UPGR  = 3'd3,
      BC_WBACK = 3'd4
   } bus_cmd_e;

   typedef enum logic [OP_W-1:0] {
      OP_RD    = 2'd0,
      OP_WR    = 2'd1,
      OP_EVICT = 2'd2,
      OP_NOP   = 2'd3
   } cpu_op_e;
endpackage

// File: rtl/mesi_snoop_react.sv
module mesi_snoop_react
   import mesi_pkg::*;
(
   input  line_state_e state_i,
   input  logic        snoop_valid_i,
   input  bus_cmd_e    snoop_cmd_i,
   output line_state_e next_state_o,
   output logic        flush_o,
   output logic        shared_o
);
   always_comb begin
      next_state_o = state_i;
      flush_o      = 1'b0;
      shared_o     = 1'b0;
      if (snoop_valid_i && state_i != LS_INV) begin
         case (snoop_cmd_i)
            BC_READ: begin
               shared_o     = 1'b1;
               flush_o      = (state_i == LS_MOD);
               next_state_o = LS_SHR;
            end
            BC_READX, BC_UPGR: begin
               flush_o      = (state_i == LS_MOD);
               next_state_o = LS_INV;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mesi_cpu_decode.sv
module mesi_cpu_decode
   import mesi_pkg::*;
#(
   parameter int UPGRADE_EN = 1
) (
   input  line_state_e state_i,
   input  cpu_op_e     op_i,
   output logic        hit_o,
   output line_state_e hit_state_o,
   output bus_cmd_e    miss_cmd_o
);
   bus_cmd_e shr_wr_cmd;

   generate
      if (UPGRADE_EN != 0) begin : g_upgr
         assign shr_wr_cmd = BC_UPGR;
      end else begin : g_readx
         assign shr_wr_cmd = BC_READX;
      end
   endgenerate

   always_comb begin
      hit_o       = 1'b1;
      hit_state_o = state_i;
      miss_cmd_o  = BC_NONE;
      case (op_i)
         OP_RD: begin
            if (state_i == LS_INV) begin
               hit_o      = 1'b0;
               miss_cmd_o = BC_READ;
            end
         end
         OP_WR: begin
            case (state_i)
               LS_EXC: hit_state_o = LS_MOD;
               LS_SHR: begin
                  hit_o      = 1'b0;
                  miss_cmd_o = shr_wr_cmd;
               end
               LS_INV: begin
                  hit_o      = 1'b0;
                  miss_cmd_o = BC_READX;
               end
               default: ;
            endcase
         end
         OP_EVICT: begin
            if (state_i == LS_MOD) begin
               hit_o      = 1'b0;
               miss_cmd_o = BC_WBACK;
            end else begin
               hit_state_o = LS_INV;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/mesi_pend_tracker.sv
module mesi_pend_tracker
   import mesi_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        load_i,
   input  bus_cmd_e    load_cmd_i,
   input  logic        grant_i,
   input  logic        snoop_valid_i,
   input  line_state_e snoop_state_i,
   output logic        valid_o,
   output bus_cmd_e    cmd_o,
   output logic        cancel_o
);
   logic taken;
   logic wb_moot;
   logic upg_lost;

   assign taken    = grant_i && valid_o;
   assign wb_moot  = valid_o && snoop_valid_i && (cmd_o == BC_WBACK) && (snoop_state_i != LS_MOD);
   assign upg_lost = valid_o && snoop_valid_i && (cmd_o == BC_UPGR) && (snoop_state_i == LS_INV);
   assign cancel_o = wb_moot && !taken;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         cmd_o   <= BC_NONE;
      end else if (taken) begin
         valid_o <= 1'b0;
         cmd_o   <= BC_NONE;
      end else if (wb_moot) begin
         valid_o <= 1'b0;
         cmd_o   <= BC_NONE;
      end else if (upg_lost) begin
         cmd_o   <= BC_READX;
      end else if (load_i && !valid_o) begin
         valid_o <= 1'b1;
         cmd_o   <= load_cmd_i;
      end
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int UPGRADE_EN = 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    cpu_valid_i,
   input  logic [OP_W-1:0]         cpu_op_i,
   output logic                    cpu_ready_o,
   output logic                    cpu_done_o,
   output logic                    bus_req_o,
   output logic [CMD_W-1:0]        bus_cmd_o,
   input  logic                    bus_grant_i,
   input  logic                    snoop_valid_i,
   input  logic [CMD_W-1:0]        snoop_cmd_i,
   input  logic                    shared_i,
   output logic                    shared_o,
   output logic                    flush_o,
   output logic [ST_W-1:0]         state_o
);
   generate
      if (UPGRADE_EN != 0 && UPGRADE_EN != 1) begin : g_bad_upgr
         $fatal(1, "UPGRADE_EN must be 0 or 1");
      end
      if ($bits(bus_cmd_e) != CMD_W || $bits(line_state_e) != ST_W) begin : g_bad_width
         $fatal(1, "encoding widths disagree with package widths");
      end
   endgenerate

   line_state_e state_q, state_d, snp_state, hit_state, grant_state;
   bus_cmd_e    miss_cmd, pend_cmd;
   logic        hit, snp_flush, pend_valid, pend_cancel;
   logic        cpu_accept, grant_take;

   assign cpu_ready_o = !pend_valid && !snoop_valid_i;
   assign cpu_accept  = cpu_valid_i && cpu_ready_o;
   assign grant_take  = bus_grant_i && pend_valid;

   mesi_snoop_react u_snoop (
      .state_i      (state_q),
      .snoop_valid_i(snoop_valid_i),
      .snoop_cmd_i  (bus_cmd_e'(snoop_cmd_i)),
      .next_state_o (snp_state),
      .flush_o      (snp_flush),
      .shared_o     (shared_o)
   );

   mesi_cpu_decode #(.UPGRADE_EN(UPGRADE_EN)) u_decode (
      .state_i    (state_q),
      .op_i       (cpu_op_e'(cpu_op_i)),
      .hit_o      (hit),
      .hit_state_o(hit_state),
      .miss_cmd_o (miss_cmd)
   );

   mesi_pend_tracker u_pend (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (cpu_accept && !hit),
      .load_cmd_i   (miss_cmd),
      .grant_i      (bus_grant_i),
      .snoop_valid_i(snoop_valid_i),
      .snoop_state_i(snp_state),
      .valid_o      (pend_valid),
      .cmd_o        (pend_cmd),
      .cancel_o     (pend_cancel)
   );

   always_comb begin
      case (pend_cmd)
         BC_READ:           grant_state = shared_i ? LS_SHR : LS_EXC;
         BC_READX, BC_UPGR: grant_state = LS_MOD;
         BC_WBACK:          grant_state = LS_INV;
         default:           grant_state = snp_state;
      endcase
   end

   always_comb begin
      if (grant_take)             state_d = grant_state;
      else if (cpu_accept && hit) state_d = hit_state;
      else                        state_d = snp_state;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= LS_INV;
      else         state_q <= state_d;
   end

   assign state_o    = state_q;
   assign bus_req_o  = pend_valid;
   assign bus_cmd_o  = pend_cmd;
   assign flush_o    = snp_flush || (grant_take && pend_cmd == BC_WBACK);
   assign cpu_done_o = (cpu_accept && hit) || grant_take || pend_cancel;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
   import mesi_pkg::*;
(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cpu_valid_i,
   input logic [OP_W-1:0]  cpu_op_i,
   input logic             cpu_ready_o,
   input logic             bus_req_o,
   input logic [CMD_W-1:0] bus_cmd_o,
   input logic             bus_grant_i,
   input logic             snoop_valid_i,
   input logic [CMD_W-1:0] snoop_cmd_i,
   input logic             shared_i,
   input logic             shared_o,
   input logic             flush_o,
   input logic [ST_W-1:0]  state_o
);
   // R7 R8: data is supplied only from a dirty copy
   p_flush_dirty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> state_o == LS_MOD);

   p_shared_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shared_o |-> (snoop_valid_i && state_o != LS_INV));

   p_exc_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_valid_i && cpu_ready_o && cpu_op_i == OP_WR && state_o == LS_EXC)
      |=> (state_o == LS_MOD && !bus_req_o));

   p_read_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_valid_i && cpu_ready_o && cpu_op_i == OP_RD && state_o != LS_INV)
      |=> (!bus_req_o && $stable(state_o)));

   p_fill_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_grant_i && bus_req_o && bus_cmd_o == BC_READ && !snoop_valid_i)
      |=> state_o == ($past(shared_i) ? LS_SHR : LS_EXC));

   p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_o && !bus_grant_i && !snoop_valid_i)
      |=> (bus_req_o && $stable(bus_cmd_o) && $stable(state_o)));

   p_snoop_inval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snoop_valid_i && (snoop_cmd_i == BC_READX || snoop_cmd_i == BC_UPGR) && !bus_grant_i)
      |=> state_o == LS_INV);

   p_upg_convert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_o && bus_cmd_o == BC_UPGR && !bus_grant_i && snoop_valid_i &&
       (snoop_cmd_i == BC_READX || snoop_cmd_i == BC_UPGR))
      |=> (bus_req_o && bus_cmd_o == BC_READX));

   p_ready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_o || snoop_valid_i) |-> !cpu_ready_o);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .cpu_valid_i  (cpu_valid_i),
   .cpu_op_i     (cpu_op_i),
   .cpu_ready_o  (cpu_ready_o),
   .bus_req_o    (bus_req_o),
   .bus_cmd_o    (bus_cmd_o),
   .bus_grant_i  (bus_grant_i),
   .snoop_valid_i(snoop_valid_i),
   .snoop_cmd_i  (snoop_cmd_i),
   .shared_i     (shared_i),
   .shared_o     (shared_o),
   .flush_o      (flush_o),
   .state_o      (state_o)
);

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       cpu_valid = 1'b0;
   logic [1:0] cpu_op = 2'd0;
   logic       bus_grant = 1'b0;
   logic       snoop_valid = 1'b0;
   logic [2:0] snoop_cmd = 3'd0;
   logic       shared_in = 1'b0;

   // index 0: upgrade variant, index 1: read-exclusive variant
   logic [1:0]      ready, done, breq, shr, flush;
   logic [1:0][2:0] bcmd;
   logic [1:0][1:0] st;

   mesi_line_ctrl #(.UPGRADE_EN(1)) u_mesi_line_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .cpu_valid_i(cpu_valid), .cpu_op_i(cpu_op),
      .cpu_ready_o(ready[0]), .cpu_done_o(done[0]), .bus_req_o(breq[0]), .bus_cmd_o(bcmd[0]),
      .bus_grant_i(bus_grant), .snoop_valid_i(snoop_valid), .snoop_cmd_i(snoop_cmd),
      .shared_i(shared_in), .shared_o(shr[0]), .flush_o(flush[0]), .state_o(st[0]));

   mesi_line_ctrl #(.UPGRADE_EN(0)) u_mesi_line_ctrl_rdx (
      .clk_i(clk), .rst_ni(rst_n), .cpu_valid_i(cpu_valid), .cpu_op_i(cpu_op),
      .cpu_ready_o(ready[1]), .cpu_done_o(done[1]), .bus_req_o(breq[1]), .bus_cmd_o(bcmd[1]),
      .bus_grant_i(bus_grant), .snoop_valid_i(snoop_valid), .snoop_cmd_i(snoop_cmd),
      .shared_i(shared_in), .shared_o(shr[1]), .flush_o(flush[1]), .state_o(st[1]));

   int n_chk = 0;
   int n_fail = 0;
   bit reported = 1'b0;

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // expected bus command for an operation (0 none, 1 read, 2 readx, 3 upgrade, 4 writeback)
   function automatic int exp_cmd(int s, int op, int upg);
      if (op == 0) return (s == 0) ? 1 : 0;
      if (op == 1) begin
         if (s == 0) return 2;
         if (s == 1) return upg ? 3 : 2;
         return 0;
      end
      if (op == 2) return (s == 3) ? 4 : 0;
      return 0;
   endfunction

   function automatic int exp_fin(int s, int op, int sh);
      if (op == 0) return (s == 0) ? (sh ? 1 : 2) : s;
      if (op == 1) return 3;
      if (op == 2) return 0;
      return s;
   endfunction

   function automatic string op_tag(int s, int op);
      if (op == 0) return (s == 0) ? "R2" : "R3";
      if (op == 1) return (s >= 2) ? "R4" : "R5";
      return "R8";
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_valid = 1'b0; bus_grant = 1'b0; snoop_valid = 1'b0; shared_in = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
   endtask

   task automatic run_cpu(input int op, input int sh);
      int s0[2];
      int ec[2];
      string tag;
      for (int d = 0; d < 2; d++) begin
         s0[d] = st[d];
         ec[d] = exp_cmd(s0[d], op, d == 0);
      end
      tag = op_tag(s0[0], op);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = 2'(op); shared_in = sh[0];
      #0.5;
      for (int d = 0; d < 2; d++)
         chk_eq({tag, " done at accept"}, done[d], ec[d] == 0);
      @(negedge clk);
      cpu_valid = 1'b0;
      #0.5;
      for (int d = 0; d < 2; d++)
         chk_eq({tag, " bus command"}, breq[d] ? int'(bcmd[d]) : 0, ec[d]);
      if (ec[0] != 0) begin
         @(negedge clk);
         bus_grant = 1'b1;
         #0.5;
         for (int d = 0; d < 2; d++) begin
            chk_eq({tag, " flush at grant"}, flush[d], ec[d] == 4);
            chk_eq({tag, " done at grant"}, done[d], 1);
         end
         @(negedge clk);
         bus_grant = 1'b0;
         #0.5;
      end
      for (int d = 0; d < 2; d++)
         chk_eq({tag, " final state"}, st[d], exp_fin(s0[d], op, sh));
   endtask

   task automatic reach(input int s);
      do_reset();
      case (s)
         1: run_cpu(0, 1);
         2: run_cpu(0, 0);
         3: run_cpu(1, 0);
         default: ;
      endcase
   endtask

   task automatic run_snoop(input int c);
      int s0;
      string tag;
      s0 = st[0];
      tag = (c == 2 || c == 3) ? "R7" : "R6";
      @(negedge clk);
      snoop_valid = 1'b1; snoop_cmd = 3'(c);
      #0.5;
      for (int d = 0; d < 2; d++) begin
         chk_eq({tag, " snoop shared"}, shr[d], (c == 1) && (s0 != 0));
         chk_eq({tag, " snoop flush"}, flush[d], (s0 == 3) && (c >= 1) && (c <= 3));
      end
      @(negedge clk);
      snoop_valid = 1'b0;
      #0.5;
      for (int d = 0; d < 2; d++)
         chk_eq({tag, " snoop state"}, st[d],
                (s0 == 0) ? 0 : (c == 1) ? 1 : (c == 2 || c == 3) ? 0 : s0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      report();
   end

   initial begin
      // R1: reset state
      do_reset();
      for (int d = 0; d < 2; d++) begin
         chk_eq("R1 reset state", st[d], 0);
         chk_eq("R1 reset request", breq[d], 0);
         chk_eq("R1 reset ready", ready[d], 1);
      end

      // processor operations from every state, both shared values
      for (int s = 0; s < 4; s++)
         for (int op = 0; op < 3; op++)
            for (int sh = 0; sh < 2; sh++) begin
               reach(s);
               run_cpu(op, sh);
            end

      // snooped commands from every state
      for (int s = 0; s < 4; s++)
         for (int c = 1; c < 5; c++) begin
            reach(s);
            run_snoop(c);
         end

      // R9 R12: request held; new request ignored while pending
      reach(0);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = 2'd0; shared_in = 1'b0;
      @(negedge clk);
      cpu_op = 2'd1;
      #0.5;
      for (int d = 0; d < 2; d++) chk_eq("R12 ready while pending", ready[d], 0);
      repeat (3) @(negedge clk);
      cpu_valid = 1'b0;
      #0.5;
      for (int d = 0; d < 2; d++) begin
         chk_eq("R9 command held", bcmd[d], 1);
         chk_eq("R9 state held", st[d], 0);
         chk_eq("R12 ignored write", breq[d], 1);
      end
      @(negedge clk);
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0;
      #0.5;
      for (int d = 0; d < 2; d++) chk_eq("R9 fill after grant", st[d], 2);

      // R10: pending upgrade invalidated by a snooped read-exclusive
      reach(1);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = 2'd1;
      @(negedge clk);
      cpu_valid = 1'b0;
      #0.5;
      chk_eq("R5 upgrade issued", bcmd[0], 3);
      chk_eq("R5 readx issued", bcmd[1], 2);
      @(negedge clk);
      snoop_valid = 1'b1; snoop_cmd = 3'd2;
      @(negedge clk);
      snoop_valid = 1'b0;
      #0.5;
      for (int d = 0; d < 2; d++) begin
         chk_eq("R10 converted command", bcmd[d], 2);
         chk_eq("R10 still requesting", breq[d], 1);
         chk_eq("R7 invalid before grant", st[d], 0);
      end
      @(negedge clk);
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0;
      #0.5;
      for (int d = 0; d < 2; d++) chk_eq("R10 modified after grant", st[d], 3);

      // R11: eviction write-back made moot by a snooped read
      reach(3);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = 2'd2;
      @(negedge clk);
      cpu_valid = 1'b0; snoop_valid = 1'b1; snoop_cmd = 3'd1;
      #0.5;
      for (int d = 0; d < 2; d++) begin
         chk_eq("R11 flush on snoop", flush[d], 1);
         chk_eq("R11 done on cancel", done[d], 1);
      end
      @(negedge clk);
      snoop_valid = 1'b0;
      #0.5;
      for (int d = 0; d < 2; d++) begin
         chk_eq("R11 request dropped", breq[d], 0);
         chk_eq("R11 state shared", st[d], 1);
      end

      report();
   end
endmodule